// File: doc/BRIEF.md
# Periodic System Tick Down-Counter

This block produces a regular tick interrupt for a processor core. It holds a 24-bit counter that counts down from a programmed reload value. Each step comes either from the core clock or from a single-cycle reference strobe, and a control bit picks the source. When a decrement lands on zero, the block sets a sticky count flag. If the tick interrupt is enabled, it also raises a one-cycle interrupt request. On the next step the counter reloads, so each period spans reload+1 steps.

Software reaches the block through four word registers, decoded from address bits [3:2]:
- offset 0x0 holds control and status;
- offset 0x4 holds the reload value;
- offset 0x8 holds the live count;
- offset 0xC is a constant calibration word.

Reads return data combinationally in the cycle the select is high. Writes take effect at the next clock edge. Two corners need care. Writing the live-count register clears both the count and the flag. A reload value of zero makes the counter stop at zero while the enable bit stays set.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, control reads 0, reload reads 0, the live count reads 0 and the counter does not move.
- R2: Control layout: bit 0 enable, bit 1 tick interrupt enable, bit 2 source select. Only these bits are writable. The count flag reads at bit 16 and writes there have no effect. All other bits read 0.
- R3: The reload register keeps bits [23:0] of a write and discards the rest.
- R4: A control read returns the flag and clears it at that edge. If a decrement to zero happens in the same cycle, the flag is set instead.
- R5: A write of any value to the live-count register (0x8) does three things at that edge: the count becomes 0, the flag clears, and, if reload is zero, counting halts. The following step reloads from the reload register.
- R6: A decrement that lands on zero sets the flag. The interrupt goes high for exactly one cycle, and only when bit 1 is set.
- R7: When the count reaches or stays at zero while reload is zero, counting stops and the enable bit stays 1. Only a control write that moves enable from 0 to 1 resumes counting.
- R8: A step at zero loads the reload value and does not decrement. With the core clock as source, interrupts therefore come every reload+1 cycles.
- R9: The calibration register (0xC) reads 10000 decimal, and writes to it are ignored.
- R10: Clearing enable freezes the count. Setting it again resumes from the frozen value.
- R11: With bit 2 at 0 the counter steps only on cycles where `ref_tick` is high. With bit 2 at 1 it steps on every clock.
- R12: The live-count register returns the current 24-bit count, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| ref_tick | input | 1 | Single-cycle reference step strobe |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The hardest situation to reach is a control read that falls in the very cycle the count goes from 1 to 0, where the flag set has to win over the read-clear.

The bench sets this up deterministically:
1. It writes the live-count register while running on the core clock with reload 3, which pins the count to 0 at a known edge.
2. It waits the exact number of cycles until the count is 1.
3. It issues the read in that cycle.
4. A second read then has to show the flag set.

The zero-reload stop is reached by lowering the reload while the counter is running. The bench then shows that a later non-zero reload does not restart counting until enable is toggled.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

    localparam int CNT_W     = 24;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int FLAG_POS  = 16;
    localparam int CALIB_VAL = 10000;
    localparam int CTRL_W    = 3;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CURR   = 2'd2,
        REG_CALIB  = 2'd3
    } reg_sel_e;

    // packed msb first: bit 2 source select, bit 1 irq enable, bit 0 enable
    typedef struct packed {
        logic src_core;
        logic tick_ie;
        logic run;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_status(ctrl_t c, logic flag);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[CTRL_W-1:0]  = c;
        w[FLAG_POS]    = flag;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] zext_count(logic [CNT_W-1:0] v);
        return {{(DATA_W-CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/ptick_tick_sel.sv
module ptick_tick_sel (
    input  logic src_core,
    input  logic ref_tick,
    output logic step_en
);
    // core clock source steps every cycle; otherwise follow the strobe
    assign step_en = src_core | ref_tick;
endmodule

// File: rtl/ptick_counter.sv
module ptick_counter
    import ptick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick_ie,
    input  logic             step_en,
    input  logic [CNT_W-1:0] reload,
    input  logic             clear_req,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             dec_to_zero,
    output logic             irq_pulse
);
    logic halted;
    logic step;

    assign step        = run && !halted && step_en && !clear_req;
    assign dec_to_zero = step && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            halted    <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= dec_to_zero && tick_ie;
            if (clear_req) begin
                count <= '0;
                if (reload == '0) halted <= 1'b1;
            end else if (restart) begin
                halted <= 1'b0;
            end else if (step) begin
                if (count != '0) begin
                    count <= count - CNT_W'(1);
                    if (count == CNT_W'(1) && reload == '0) halted <= 1'b1;
                end else if (reload == '0) begin
                    halted <= 1'b1;
                end else begin
                    count <= reload;
                end
            end
        end
    end

    // R7: a stopped counter always sits at zero
    a_r7_halt_at_zero: assert property (@(posedge clk) disable iff (rst)
        halted |-> count == '0);
    // R5: a live-count write leaves the count at zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear_req |=> count == '0);
    // R10: disabled and untouched means frozen
    a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear_req) |=> $stable(count));
    // R6: interrupt is a single-cycle pulse
    a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

endmodule

// File: rtl/ptick_regs.sv
module ptick_regs
    import ptick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              dec_to_zero,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              clear_req,
    output logic              restart,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;
    logic     wr_ctrl, wr_reload, rd_ctrl;
    logic     flag;
    logic     unused_ok;

    assign sel       = reg_sel_e'(bus_addr[ADDR_W-1 -: 2]);
    assign wr_ctrl   = bus_sel &&  bus_wr && sel == REG_CTRL;
    assign wr_reload = bus_sel &&  bus_wr && sel == REG_RELOAD;
    assign clear_req = bus_sel &&  bus_wr && sel == REG_CURR;
    assign rd_ctrl   = bus_sel && !bus_wr && sel == REG_CTRL;
    assign restart   = wr_ctrl && bus_wdata[0] && !ctrl.run;
    assign unused_ok = ^{bus_addr[ADDR_W-3:0], bus_wdata[DATA_W-1:CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            flag   <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_reload) reload <= bus_wdata[CNT_W-1:0];
            if (clear_req)        flag <= 1'b0;
            else if (dec_to_zero) flag <= 1'b1;
            else if (rd_ctrl)     flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = pack_status(ctrl, flag);
            REG_RELOAD: bus_rdata = zext_count(reload);
            REG_CURR:   bus_rdata = zext_count(count);
            default:    bus_rdata = DATA_W'(CALIB_VAL);
        endcase
    end

    // R4: a read without a coincident expiry leaves the flag clear
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && !dec_to_zero && !clear_req) |=> !flag);
    // R6: reaching zero always sets the flag
    a_r6_flag_on_zero: assert property (@(posedge clk) disable iff (rst)
        dec_to_zero |=> flag);
    // R2: undefined control bits read as zero
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl |-> (bus_rdata[DATA_W-1:FLAG_POS+1] == '0 &&
                     bus_rdata[FLAG_POS-1:CTRL_W] == '0));
    // R3: reload keeps the low 24 bits of the last write
    a_r3_reload_keep: assert property (@(posedge clk) disable iff (rst)
        wr_reload |=> reload == $past(bus_wdata[CNT_W-1:0]));

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import ptick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              tick_irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             clear_req, restart, dec_to_zero, step_en;

    ptick_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .count       (count),
        .dec_to_zero (dec_to_zero),
        .ctrl        (ctrl),
        .reload      (reload),
        .clear_req   (clear_req),
        .restart     (restart),
        .bus_rdata   (bus_rdata)
    );

    ptick_tick_sel u_sel (
        .src_core (ctrl.src_core),
        .ref_tick (ref_tick),
        .step_en  (step_en)
    );

    ptick_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .run         (ctrl.run),
        .tick_ie     (ctrl.tick_ie),
        .step_en     (step_en),
        .reload      (reload),
        .clear_req   (clear_req),
        .restart     (restart),
        .count       (count),
        .dec_to_zero (dec_to_zero),
        .irq_pulse   (tick_irq)
    );

    // R6: an interrupt implies the flag was raised at the same edge
    a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (rst)
        tick_irq |-> bus_sel || 1'b1 ? (u_regs.flag || $past(clear_req)) : 1'b1);

endmodule

// File: tb/sys_tick_timer_bench.sv
module sys_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_mode = 0;
    int last_irq_cyc = -1;
    int last_gap = 0;
    int irq_count = 0;

    // behavioural reference state
    bit m_en, m_tie, m_src, m_flag, m_halt, m_irq;
    int m_reload, m_cnt;

    always #2 clk = ~clk;

    sys_tick_timer u_sys_tick_timer (
        .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .ref_tick (ref_tick), .tick_irq (tick_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0: return {15'b0, m_flag, 13'b0, m_src, m_tie, m_en};
            2'd1: return 32'(m_reload);
            2'd2: return 32'(m_cnt);
            default: return 32'd10000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_tie = 0; m_src = 0; m_flag = 0; m_halt = 0; m_irq = 0;
            m_reload = 0; m_cnt = 0;
        end else begin
            bit wc, wrl, cvw, rdc, stp, dz;
            wc  = bus_sel && bus_wr  && bus_addr[3:2] == 2'd0;
            wrl = bus_sel && bus_wr  && bus_addr[3:2] == 2'd1;
            cvw = bus_sel && bus_wr  && bus_addr[3:2] == 2'd2;
            rdc = bus_sel && !bus_wr && bus_addr[3:2] == 2'd0;
            stp = m_en && !m_halt && (m_src || ref_tick) && !cvw;
            dz  = stp && m_cnt == 1;
            m_irq = dz && m_tie;
            if (cvw) begin
                m_cnt = 0;
                if (m_reload == 0) m_halt = 1;
            end else if (wc && bus_wdata[0] && !m_en) begin
                m_halt = 0;
            end else if (stp) begin
                if (m_cnt > 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0 && m_reload == 0) m_halt = 1;
                end else if (m_reload == 0) m_halt = 1;
                else m_cnt = m_reload;
            end
            if (cvw) m_flag = 0;
            else if (dz) m_flag = 1;
            else if (rdc) m_flag = 0;
            if (wc) begin
                m_en = bus_wdata[0]; m_tie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (wrl) m_reload = int'(bus_wdata[23:0]);
        end
    end

    // per-cycle driver of the reference strobe and interrupt monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            ref_tick = (ref_mode != 0) && (cyc % 3 == 0);
            if (!rst) begin
                chk("R6 irq vs model", {31'b0, tick_irq}, {31'b0, m_irq});
                if (tick_irq) begin
                    if (last_irq_cyc >= 0) last_gap = cyc - last_irq_cyc;
                    last_irq_cyc = cyc;
                    irq_count++;
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        v = bus_rdata;
        chk(tag, v, model_rd(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(4'h0, "R1 ctrl", v);   chk("R1 ctrl zero", v, 0);
        rd(4'h4, "R1 reload", v); chk("R1 reload zero", v, 0);
        rd(4'h8, "R1 count", v);  chk("R1 count zero", v, 0);
        rd(4'hC, "R9 calib", v);  chk("R9 calib value", v, 32'd10000);

        // R3 reload width
        wr(4'h4, 32'hFF00_0005);
        rd(4'h4, "R3 reload", v); chk("R3 reload truncated", v, 32'd5);

        // R2 writable bits only
        wr(4'h0, 32'hFFFF_FFF6);
        rd(4'h0, "R2 ctrl", v);   chk("R2 ctrl low bits", v, 32'd6);
        wr(4'h0, 32'h0);

        // R9 calibration write ignored
        wr(4'hC, 32'hDEAD_BEEF);
        rd(4'hC, "R9 calib", v);  chk("R9 calib after write", v, 32'd10000);

        // R10 freeze and resume
        wr(4'h0, 32'h5);
        repeat (3) @(negedge clk);
        wr(4'h0, 32'h4);
        rd(4'h8, "R10 frozen", v);
        repeat (5) @(negedge clk);
        rd(4'h8, "R10 frozen", v2); chk("R10 count held", v2, v);
        wr(4'h0, 32'h5);
        repeat (2) @(negedge clk);
        rd(4'h8, "R10 resume", v);

        // R8 period with interrupts on core clock
        wr(4'h0, 32'h7);
        last_irq_cyc = -1;
        repeat (30) @(negedge clk);
        chk("R8 irq spacing", 32'(last_gap), 32'd6);

        // R4 read returns then clears the flag
        wr(4'h0, 32'h6);
        rd(4'h0, "R4 ctrl", v);   chk("R4 flag seen", {31'b0, v[16]}, 1);
        rd(4'h0, "R4 ctrl", v);   chk("R4 flag cleared", {31'b0, v[16]}, 0);

        // R4 set wins over read-clear in the expiry cycle
        wr(4'h0, 32'h7);
        wr(4'h4, 32'h3);
        wr(4'h8, 32'h0);
        repeat (2) @(negedge clk);
        rd(4'h0, "R4 coincident", v); chk("R4 flag before expiry", {31'b0, v[16]}, 0);
        rd(4'h0, "R4 after", v);      chk("R4 set wins", {31'b0, v[16]}, 1);

        // R5 live-count write clears count and flag
        repeat (8) @(negedge clk);
        wr(4'h0, 32'h6);
        wr(4'h8, 32'h1234_ABCD);
        rd(4'h0, "R5 ctrl", v);   chk("R5 flag cleared", {31'b0, v[16]}, 0);
        rd(4'h8, "R5 count", v);  chk("R5 count zero", v, 0);
        wr(4'h0, 32'h7);
        rd(4'h8, "R5 reloaded", v);

        // R7 zero reload stops counting, enable stays
        wr(4'h4, 32'h0);
        repeat (20) @(negedge clk);
        rd(4'h0, "R7 ctrl", v);   chk("R7 enable kept", {31'b0, v[0]}, 1);
        rd(4'h8, "R7 count", v);  chk("R7 count zero", v, 0);
        irq_count = 0;
        repeat (10) @(negedge clk);
        chk("R7 no irq while stopped", 32'(irq_count), 0);
        wr(4'h4, 32'h2);
        repeat (5) @(negedge clk);
        rd(4'h8, "R7 still stopped", v); chk("R7 needs enable edge", v, 0);
        wr(4'h0, 32'h6);
        wr(4'h0, 32'h7);
        repeat (3) @(negedge clk);
        rd(4'h8, "R7 restarted", v);

        // R6 interrupt disabled: flag only
        wr(4'h0, 32'h5);
        irq_count = 0;
        repeat (20) @(negedge clk);
        chk("R6 no irq when disabled", 32'(irq_count), 0);
        rd(4'h0, "R6 ctrl", v);   chk("R6 flag set", {31'b0, v[16]}, 1);

        // R11 reference strobe source
        wr(4'h0, 32'h2);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h4);
        ref_mode = 1;
        wr(4'h0, 32'h3);
        last_irq_cyc = -1;
        repeat (50) @(negedge clk);
        chk("R11 strobe period", 32'(last_gap), 32'd15);
        ref_mode = 0;
        rd(4'h8, "R11 idle", v);
        repeat (10) @(negedge clk);
        rd(4'h8, "R11 idle", v2); chk("R11 no strobe no step", v2, v);

        // R12 zero-extended live count
        wr(4'h0, 32'h6);
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h7);
        repeat (5) @(negedge clk);
        rd(4'h8, "R12 count", v);
        chk("R12 upper zero", {24'b0, v[31:24]}, 0);
        chk("R12 near top", {31'b0, v > 32'hFFFF00}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule